// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block is the coherence engine for one small direct-mapped private cache that sits on a shared snooping bus with main memory behind it. Each line carries one of three states: Invalid, Shared or Modified. Processor reads and writes are served locally when the state allows it. Otherwise the controller places a read-miss or write-miss request on the bus and waits for the grant, when memory delivers the line. The controller also watches the requests of the other caches on the bus. It downgrades or drops its own copy, and it pushes a dirty line back to memory whenever another agent needs it.

A dirty copy is never thrown away silently. A requester that writes may change only a few bytes of the line, so the bytes it leaves alone must reach memory before the local copy is lost. A Modified line that is displaced by a conflicting fill is treated the same way.

Addresses are line addresses, split as {tag, index}. The processor port moves a whole line and uses per-byte enables for writes. Memory always supplies the data on a miss, even when another cache holds the line Shared.

Top module: `msi_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid and `cpu_resp_valid`, `bus_req_valid` and `wb_valid` are low.
- R2: A processor read to a line that is not present raises `bus_req_valid` with `bus_req_kind`=0 (read miss) and the line address, and holds it until granted. The grant cycle's `bus_rdata` is stored as Shared and returned on `cpu_resp_valid` in the next cycle.
- R3: A processor read that hits a Shared or Modified line returns the stored line with `cpu_resp_valid` one cycle after acceptance, with no bus request. The response is a single-cycle pulse.
- R4: A processor write to an Invalid or Shared line raises a bus request with `bus_req_kind`=1 (write miss). On grant the line becomes Modified, holding the processor bytes where enabled and the `bus_rdata` bytes elsewhere, and the merged line is returned.
- R5: A processor write that hits a Modified line merges the enabled bytes into the stored line and responds with no bus request.
- R6: A miss whose index holds a Modified line with a different tag pulses `wb_valid` with that victim's address and data. The pulse comes in the same cycle that the bus request first appears, before any grant.
- R7: A snooped write miss (`snp_kind`=1) that matches a Modified line pulses `wb_valid` one cycle later with the full line, and leaves the line Invalid.
- R8: A snooped write miss that matches a Shared line invalidates it with no write-back.
- R9: A snooped read miss (`snp_kind`=0) that matches a Modified line writes it back and leaves it Shared, so later reads still hit and later writes need a write-miss request.
- R10: A snoop whose tag differs from the stored tag leaves the line unchanged.
- R11: A snoop in the same cycle as a new processor request is applied first. The request is accepted in a later cycle and sees the updated line state. No response and no grant are taken in a snoop cycle.
- R12: Byte enable bit i covers line bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req_valid | input | 1 | Processor request, held until the response |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address {tag, index} |
| cpu_req_wdata | input | 8*LINE_BYTES | Write line data |
| cpu_req_be | input | LINE_BYTES | Byte enables for writes |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | 8*LINE_BYTES | Line contents after the access |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_kind | output | 1 | 0 = read miss, 1 = write miss |
| bus_req_addr | output | ADDR_W | Requested line address |
| bus_gnt | input | 1 | Grant; memory data valid this cycle |
| bus_rdata | input | 8*LINE_BYTES | Line from memory |
| snp_valid | input | 1 | Another cache's request seen on the bus |
| snp_kind | input | 1 | 0 = read miss, 1 = write miss |
| snp_addr | input | ADDR_W | Snooped line address |
| wb_valid | output | 1 | Write-back pulse to memory |
| wb_addr | output | ADDR_W | Write-back line address |
| wb_data | output | 8*LINE_BYTES | Write-back line data |

## Verification
The processor side is driven with read misses, read hits, partial and full-line writes, and a conflicting fill over a dirty line. These cases separate a fill into Shared from a merge into Modified, and a silent write hit from a write-miss upgrade. The snoop side is tried with write misses and read misses against Modified, Shared and tag-mismatched lines. A follow-up read or write then shows, through bus activity alone, whether the line ended Invalid, Shared or untouched. A snoop that lands together with a processor read of the same line shows whether the snoop really takes precedence: with correct ordering the read misses instead of hitting.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHD = 2'd1,
        LN_MOD = 2'd2
    } line_st_e;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_BUS  = 1'b1
    } ctl_st_e;

    localparam logic KIND_RD = 1'b0;
    localparam logic KIND_WR = 1'b1;

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
#(
    parameter int NUM_SETS = 16,
    parameter int TAG_W    = 12,
    parameter int DATA_W   = 64,
    localparam int IDX_W   = $clog2(NUM_SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  line_st_e          wst,
    input  logic [TAG_W-1:0]  wtag,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ra_idx,
    output line_st_e          ra_st,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output line_st_e          rb_st,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [DATA_W-1:0] rb_data
);

    line_st_e          st_q   [NUM_SETS];
    logic [TAG_W-1:0]  tag_q  [NUM_SETS];
    logic [DATA_W-1:0] data_q [NUM_SETS];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[s]   <= LN_INV;
                tag_q[s]  <= '0;
                data_q[s] <= '0;
            end else if (we && (widx == IDX_W'(s))) begin
                st_q[s]   <= wst;
                tag_q[s]  <= wtag;
                data_q[s] <= wdata;
            end
        end
    end

    assign ra_st   = st_q[ra_idx];
    assign ra_tag  = tag_q[ra_idx];
    assign ra_data = data_q[ra_idx];
    assign rb_st   = st_q[rb_idx];
    assign rb_tag  = tag_q[rb_idx];
    assign rb_data = data_q[rb_idx];

endmodule

// File: rtl/msi_byte_merge.sv
module msi_byte_merge #(
    parameter int BYTES = 8,
    localparam int W    = 8 * BYTES
) (
    input  logic [W-1:0]     base,
    input  logic [W-1:0]     upd,
    input  logic [BYTES-1:0] be,
    output logic [W-1:0]     merged
);

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign merged[8*b +: 8] = be[b] ? upd[8*b +: 8] : base[8*b +: 8];
    end

endmodule

// File: rtl/msi_snoop_eval.sv
module msi_snoop_eval
    import msi_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             kind,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_e         line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             hit,
    output logic             need_wb,
    output line_st_e         next_st
);

    always_comb begin
        hit     = (line_st != LN_INV) && (line_tag == snp_tag);
        need_wb = hit && (line_st == LN_MOD);
        next_st = line_st;
        if (hit) begin
            if (kind == KIND_WR) begin
                next_st = LN_INV;
            end else if (line_st == LN_MOD) begin
                next_st = LN_SHD;
            end
        end
    end

endmodule

// File: rtl/msi_coherence_ctrl.sv
module msi_coherence_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NUM_SETS   = 16,
    parameter int LINE_BYTES = 8,
    localparam int LINE_W    = 8 * LINE_BYTES,
    localparam int IDX_W     = $clog2(NUM_SETS),
    localparam int TAG_W     = ADDR_W - IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req_valid,
    input  logic                  cpu_req_write,
    input  logic [ADDR_W-1:0]     cpu_req_addr,
    input  logic [LINE_W-1:0]     cpu_req_wdata,
    input  logic [LINE_BYTES-1:0] cpu_req_be,
    output logic                  cpu_resp_valid,
    output logic [LINE_W-1:0]     cpu_resp_rdata,
    output logic                  bus_req_valid,
    output logic                  bus_req_kind,
    output logic [ADDR_W-1:0]     bus_req_addr,
    input  logic                  bus_gnt,
    input  logic [LINE_W-1:0]     bus_rdata,
    input  logic                  snp_valid,
    input  logic                  snp_kind,
    input  logic [ADDR_W-1:0]     snp_addr,
    output logic                  wb_valid,
    output logic [ADDR_W-1:0]     wb_addr,
    output logic [LINE_W-1:0]     wb_data
);

    typedef struct packed {
        ctl_st_e               ctl;
        logic                  req_wr;
        logic [ADDR_W-1:0]     req_addr;
        logic [LINE_W-1:0]     req_wdata;
        logic [LINE_BYTES-1:0] req_be;
        logic                  resp_v;
        logic [LINE_W-1:0]     resp_data;
        logic                  wb_v;
        logic [ADDR_W-1:0]     wb_addr;
        logic [LINE_W-1:0]     wb_data;
    } ctl_regs_t;

    ctl_regs_t q, d;

    // current access: live inputs while idle, latched copy while on the bus
    logic                  in_idle;
    logic [ADDR_W-1:0]     cur_addr;
    logic [LINE_W-1:0]     cur_wdata;
    logic [LINE_BYTES-1:0] cur_be;
    logic [IDX_W-1:0]      cur_idx;
    logic [TAG_W-1:0]      cur_tag;

    assign in_idle   = (q.ctl == CTL_IDLE);
    assign cur_addr  = in_idle ? cpu_req_addr  : q.req_addr;
    assign cur_wdata = in_idle ? cpu_req_wdata : q.req_wdata;
    assign cur_be    = in_idle ? cpu_req_be    : q.req_be;
    assign cur_idx   = cur_addr[IDX_W-1:0];
    assign cur_tag   = cur_addr[ADDR_W-1:IDX_W];

    // line store
    logic              st_we;
    logic [IDX_W-1:0]  st_widx;
    line_st_e          st_wst;
    logic [TAG_W-1:0]  st_wtag;
    logic [LINE_W-1:0] st_wdata;
    line_st_e          ra_st, rb_st;
    logic [TAG_W-1:0]  ra_tag, rb_tag;
    logic [LINE_W-1:0] ra_data, rb_data;

    msi_line_store #(
        .NUM_SETS (NUM_SETS),
        .TAG_W    (TAG_W),
        .DATA_W   (LINE_W)
    ) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (st_we),
        .widx    (st_widx),
        .wst     (st_wst),
        .wtag    (st_wtag),
        .wdata   (st_wdata),
        .ra_idx  (cur_idx),
        .ra_st   (ra_st),
        .ra_tag  (ra_tag),
        .ra_data (ra_data),
        .rb_idx  (snp_addr[IDX_W-1:0]),
        .rb_st   (rb_st),
        .rb_tag  (rb_tag),
        .rb_data (rb_data)
    );

    // byte merge: stored line on a write hit, memory line on a grant
    logic [LINE_W-1:0] merge_base, merged;

    assign merge_base = in_idle ? ra_data : bus_rdata;

    msi_byte_merge #(
        .BYTES (LINE_BYTES)
    ) i_merge (
        .base   (merge_base),
        .upd    (cur_wdata),
        .be     (cur_be),
        .merged (merged)
    );

    // snoop decision
    logic     snp_hit, snp_wb;
    line_st_e snp_next;

    msi_snoop_eval #(
        .TAG_W (TAG_W)
    ) i_snoop (
        .kind     (snp_kind),
        .snp_tag  (snp_addr[ADDR_W-1:IDX_W]),
        .line_st  (rb_st),
        .line_tag (rb_tag),
        .hit      (snp_hit),
        .need_wb  (snp_wb),
        .next_st  (snp_next)
    );

    logic loc_hit;
    assign loc_hit = (ra_st != LN_INV) && (ra_tag == cur_tag);

    always_comb begin
        d        = q;
        d.resp_v = 1'b0;
        d.wb_v   = 1'b0;
        st_we    = 1'b0;
        st_widx  = cur_idx;
        st_wst   = LN_INV;
        st_wtag  = cur_tag;
        st_wdata = merged;

        if (snp_valid) begin
            if (snp_hit) begin
                st_we    = 1'b1;
                st_widx  = snp_addr[IDX_W-1:0];
                st_wst   = snp_next;
                st_wtag  = rb_tag;
                st_wdata = rb_data;
                if (snp_wb) begin
                    d.wb_v    = 1'b1;
                    d.wb_addr = snp_addr;
                    d.wb_data = rb_data;
                end
            end
        end else begin
            unique case (q.ctl)
                CTL_IDLE: begin
                    if (cpu_req_valid && !q.resp_v) begin
                        d.req_wr    = cpu_req_write;
                        d.req_addr  = cpu_req_addr;
                        d.req_wdata = cpu_req_wdata;
                        d.req_be    = cpu_req_be;
                        if (!cpu_req_write && loc_hit) begin
                            d.resp_v    = 1'b1;
                            d.resp_data = ra_data;
                        end else if (cpu_req_write && loc_hit && (ra_st == LN_MOD)) begin
                            st_we       = 1'b1;
                            st_wst      = LN_MOD;
                            st_wdata    = merged;
                            d.resp_v    = 1'b1;
                            d.resp_data = merged;
                        end else begin
                            d.ctl = CTL_BUS;
                            if ((ra_st == LN_MOD) && !loc_hit) begin
                                d.wb_v    = 1'b1;
                                d.wb_addr = {ra_tag, cur_idx};
                                d.wb_data = ra_data;
                                st_we     = 1'b1;
                                st_wst    = LN_INV;
                                st_wtag   = ra_tag;
                                st_wdata  = ra_data;
                            end
                        end
                    end
                end
                CTL_BUS: begin
                    if (bus_gnt) begin
                        st_we    = 1'b1;
                        st_wtag  = cur_tag;
                        if (q.req_wr) begin
                            st_wst   = LN_MOD;
                            st_wdata = merged;
                        end else begin
                            st_wst   = LN_SHD;
                            st_wdata = bus_rdata;
                        end
                        d.resp_v    = 1'b1;
                        d.resp_data = st_wdata;
                        d.ctl       = CTL_IDLE;
                    end
                end
                default: d.ctl = CTL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cpu_resp_valid = q.resp_v;
    assign cpu_resp_rdata = q.resp_data;
    assign bus_req_valid  = (q.ctl == CTL_BUS);
    assign bus_req_kind   = q.req_wr;
    assign bus_req_addr   = q.req_addr;
    assign wb_valid       = q.wb_v;
    assign wb_addr        = q.wb_addr;
    assign wb_data        = q.wb_data;

endmodule

// File: rtl/msi_coherence_chk.sv
module msi_coherence_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_req_valid,
    input logic cpu_resp_valid,
    input logic bus_req_valid,
    input logic bus_gnt,
    input logic snp_valid,
    input logic wb_valid
);

    AST_BUSREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && (!bus_gnt || snp_valid)) |=> bus_req_valid); // R2

    AST_GRANT_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_gnt && !snp_valid) |=> (cpu_resp_valid && !bus_req_valid)); // R4

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |=> !cpu_resp_valid); // R3

    AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |=> !cpu_resp_valid); // R11

    AST_WB_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ($past(snp_valid) || $past(cpu_req_valid))); // R7

    AST_EVICT_STARTS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !$past(snp_valid)) |-> bus_req_valid); // R6

endmodule

bind msi_coherence_ctrl msi_coherence_chk i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_resp_valid (cpu_resp_valid),
    .bus_req_valid  (bus_req_valid),
    .bus_gnt        (bus_gnt),
    .snp_valid      (snp_valid),
    .wb_valid       (wb_valid)
);

// File: tb/test_msi_coherence_ctrl.sv
module test_msi_coherence_ctrl;

    localparam int AW = 8;
    localparam int NS = 4;
    localparam int LB = 4;
    localparam int LW = 8 * LB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0;
    logic          cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [LW-1:0] cpu_req_wdata = '0;
    logic [LB-1:0] cpu_req_be = '0;
    logic          cpu_resp_valid;
    logic [LW-1:0] cpu_resp_rdata;
    logic          bus_req_valid;
    logic          bus_req_kind;
    logic [AW-1:0] bus_req_addr;
    logic          bus_gnt = 1'b0;
    logic [LW-1:0] bus_rdata = '0;
    logic          snp_valid = 1'b0;
    logic          snp_kind = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic          wb_valid;
    logic [AW-1:0] wb_addr;
    logic [LW-1:0] wb_data;

    always #10 clk = ~clk; // 50 MHz

    msi_coherence_ctrl #(
        .ADDR_W     (AW),
        .NUM_SETS   (NS),
        .LINE_BYTES (LB)
    ) i_msi_coherence_ctrl (.*);

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    // observations of one access; bus kind: 0 none, 1 read miss, 2 write miss
    logic [1:0]    o_bus;
    logic [AW-1:0] o_bus_addr;
    logic [LW-1:0] o_rdata;
    logic          o_wb;
    logic [AW-1:0] o_wb_addr;
    logic [LW-1:0] o_wb_data;

    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [LW-1:0] wd,
                          input logic [LB-1:0] be, input logic [LW-1:0] mem,
                          input logic sn_en, input logic sn_kind, input logic [AW-1:0] sn_a);
        @(negedge clk);
        o_bus = 2'd0; o_bus_addr = '0; o_rdata = 'x; o_wb = 1'b0; o_wb_addr = '0; o_wb_data = '0;
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a;
        cpu_req_wdata = wd; cpu_req_be = be;
        snp_valid = sn_en; snp_kind = sn_kind; snp_addr = sn_a;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            snp_valid = 1'b0;
            if (wb_valid) begin
                o_wb = 1'b1; o_wb_addr = wb_addr; o_wb_data = wb_data;
            end
            if (cpu_resp_valid) begin
                o_rdata = cpu_resp_rdata;
                cpu_req_valid = 1'b0;
                bus_gnt = 1'b0;
                break;
            end
            if (bus_gnt) begin
                bus_gnt = 1'b0;
            end else if (bus_req_valid) begin
                o_bus = bus_req_kind ? 2'd2 : 2'd1;
                o_bus_addr = bus_req_addr;
                bus_gnt = 1'b1;
                bus_rdata = mem;
            end
        end
        cpu_req_valid = 1'b0;
    endtask

    task automatic snoop(input logic kind, input logic [AW-1:0] a);
        @(negedge clk);
        snp_valid = 1'b1; snp_kind = kind; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0;
        o_wb = wb_valid; o_wb_addr = wb_addr; o_wb_data = wb_data;
    endtask

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [LW-1:0] wdata;
        logic [LB-1:0] be;
        logic [LW-1:0] mem;
        logic [1:0]    bus;
        logic [LW-1:0] rdata;
        logic          wb;
        logic [AW-1:0] wb_addr;
        logic [LW-1:0] wb_data;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b0, 8'h10, 32'h0,        4'h0, 32'hAABBCCDD, 2'd1, 32'hAABBCCDD, 1'b0, 8'h00, 32'h0},        // R2 fill
        '{1'b0, 8'h10, 32'h0,        4'h0, 32'h0,        2'd0, 32'hAABBCCDD, 1'b0, 8'h00, 32'h0},        // R3 hit S
        '{1'b1, 8'h10, 32'h11223344, 4'h1, 32'h55667788, 2'd2, 32'h55667744, 1'b0, 8'h00, 32'h0},        // R4 R12 upgrade
        '{1'b1, 8'h10, 32'h99000000, 4'h8, 32'h0,        2'd0, 32'h99667744, 1'b0, 8'h00, 32'h0},        // R5 R12 hit M
        '{1'b0, 8'h10, 32'h0,        4'h0, 32'h0,        2'd0, 32'h99667744, 1'b0, 8'h00, 32'h0},        // R3 hit M
        '{1'b0, 8'h14, 32'h0,        4'h0, 32'h01020304, 2'd1, 32'h01020304, 1'b1, 8'h10, 32'h99667744}, // R6 evict
        '{1'b1, 8'h21, 32'hDEADBEEF, 4'hF, 32'h0,        2'd2, 32'hDEADBEEF, 1'b0, 8'h00, 32'h0},        // R4 write I
        '{1'b0, 8'h21, 32'h0,        4'h0, 32'h0,        2'd0, 32'hDEADBEEF, 1'b0, 8'h00, 32'h0},        // R3
        '{1'b1, 8'h32, 32'h00ABCD00, 4'h6, 32'h12345678, 2'd2, 32'h12ABCD78, 1'b0, 8'h00, 32'h0},        // R12 middle bytes
        '{1'b0, 8'h14, 32'h0,        4'h0, 32'h0,        2'd0, 32'h01020304, 1'b0, 8'h00, 32'h0}         // R3
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 resp_valid in reset", 32'(cpu_resp_valid), 32'd0);
        chk("R1 bus_req_valid in reset", 32'(bus_req_valid), 32'd0);
        chk("R1 wb_valid in reset", 32'(wb_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VECS[i]) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].be, VECS[i].mem, 1'b0, 1'b0, '0);
            chk($sformatf("R2/R4 vec %0d bus kind", i), 32'(o_bus), 32'(VECS[i].bus));
            if (VECS[i].bus != 2'd0)
                chk($sformatf("R2 vec %0d bus addr", i), 32'(o_bus_addr), 32'(VECS[i].addr));
            chk($sformatf("R3/R5 vec %0d rdata", i), o_rdata, VECS[i].rdata);
            chk($sformatf("R6 vec %0d wb", i), 32'(o_wb), 32'(VECS[i].wb));
            if (VECS[i].wb) begin
                chk($sformatf("R6 vec %0d wb addr", i), 32'(o_wb_addr), 32'(VECS[i].wb_addr));
                chk($sformatf("R6 vec %0d wb data", i), o_wb_data, VECS[i].wb_data);
            end
        end

        // R7: write-miss snoop on Modified line 0x21
        snoop(1'b1, 8'h21);
        chk("R7 wb pulse", 32'(o_wb), 32'd1);
        chk("R7 wb addr", 32'(o_wb_addr), 32'h21);
        chk("R7 wb data", o_wb_data, 32'hDEADBEEF);
        access(1'b0, 8'h21, '0, '0, 32'hCAFEF00D, 1'b0, 1'b0, '0);
        chk("R7 line invalid, read misses", 32'(o_bus), 32'd1);
        chk("R7 refill data", o_rdata, 32'hCAFEF00D);

        // R9: read-miss snoop on Modified line 0x32
        snoop(1'b0, 8'h32);
        chk("R9 wb pulse", 32'(o_wb), 32'd1);
        chk("R9 wb data", o_wb_data, 32'h12ABCD78);
        access(1'b0, 8'h32, '0, '0, 32'h0, 1'b0, 1'b0, '0);
        chk("R9 read still hits", 32'(o_bus), 32'd0);
        chk("R9 read data", o_rdata, 32'h12ABCD78);
        access(1'b1, 8'h32, 32'h000000FF, 4'h1, 32'h12ABCD78, 1'b0, 1'b0, '0);
        chk("R9 line Shared, write misses", 32'(o_bus), 32'd2);
        chk("R9 merged", o_rdata, 32'h12ABCDFF);

        // R8: write-miss snoop on Shared line 0x14
        snoop(1'b1, 8'h14);
        chk("R8 no wb", 32'(o_wb), 32'd0);
        access(1'b0, 8'h14, '0, '0, 32'h0A0B0C0D, 1'b0, 1'b0, '0);
        chk("R8 line invalid, read misses", 32'(o_bus), 32'd1);
        chk("R8 no wb on refill", 32'(o_wb), 32'd0);

        // R10: snoop with different tag at index 1
        snoop(1'b1, 8'h25);
        chk("R10 no wb", 32'(o_wb), 32'd0);
        access(1'b0, 8'h21, '0, '0, 32'h0, 1'b0, 1'b0, '0);
        chk("R10 line kept, read hits", 32'(o_bus), 32'd0);
        chk("R10 data kept", o_rdata, 32'hCAFEF00D);

        // R11: snoop and local read in the same cycle
        access(1'b0, 8'h21, '0, '0, 32'h77777777, 1'b1, 1'b1, 8'h21);
        chk("R11 snoop first, read misses", 32'(o_bus), 32'd1);
        chk("R11 data from memory", o_rdata, 32'h77777777);

        // R1: reset mid-run clears all lines
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        access(1'b0, 8'h21, '0, '0, 32'h00000001, 1'b0, 1'b0, '0);
        chk("R1 line invalid after reset", 32'(o_bus), 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule